// File: doc/BRIEF.md
# Token Response Event Classifier

This block sits on the response input of a token-coherence home node. It keeps one token counter for each cache line in a small table. Each response arrives through a valid/ready handshake and carries a message type, a line index and a token count. The block adds the incoming count to the stored counter for that line. The result decides which single event code it raises. The test is whether the total lands exactly on the system-wide token total, so the message type alone does not set the event.

A separate send-tokens command gives up every token held for one line. The block reports the released count and clears the counter. A line that holds nothing produces no message. A coherence controller uses the event stream to drive its own state machine. It uses the send command when a requester or starving agent must receive the home node's tokens.

Top module: `tok_resp_classifier`

## Requirements
- R1: After synchronous reset, every line's counter holds MAX_TOKENS (default 16), `evt_valid`, `send_valid`, `illegal_err` and `overflow_err` are 0, and `rsp_ready` is 1 while `send_req` is 0.
- R2: A response handshake (`rsp_valid` and `rsp_ready` both 1 at a rising edge) raises `evt_valid` for exactly the following cycle, with `evt_line` equal to the accepted line. Without a handshake `evt_valid` is 0 and `evt_code` is 0.
- R3: When stored plus incoming tokens equals MAX_TOKENS, the event code depends on the type. Owner data (type 3) or shared data (type 2) gives code 1. An owner acknowledgement (type 1) gives code 2. A plain acknowledgement (type 0) gives code 3.
- R4: When stored plus incoming tokens is below MAX_TOKENS, the event code depends on the type. Owner data (type 3) gives code 4. A plain acknowledgement or shared data (type 0 or 2) gives code 5. An owner acknowledgement (type 1) gives code 6.
- R5: A response of type 4 to 7, or one that carries zero tokens, gives code 7. It pulses `illegal_err` with the event and leaves the counter unchanged.
- R6: A legal response that does not overflow adds its token count to the line's counter.
- R7: A legal response whose sum exceeds MAX_TOKENS gives code 7 and leaves the counter unchanged. It also sets `overflow_err`, which stays 1 until reset.
- R8: A `send_req` for a line whose counter is above zero raises `send_valid` in the next cycle, with `send_count` equal to the whole counter, and the counter becomes 0. A `send_req` for an empty line leaves `send_valid` at 0 and `send_count` at 0.
- R9: While `send_req` is 1, `rsp_ready` is 0, so a response offered in that cycle is not accepted and raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rsp_valid | input | 1 | Response offered |
| rsp_ready | output | 1 | Response can be taken this cycle |
| rsp_type | input | 3 | Message type (0 ack, 1 owner ack, 2 shared data, 3 owner data) |
| rsp_line | input | IDX_W | Line index of the response |
| rsp_tokens | input | TOK_W | Tokens carried by the response |
| send_req | input | 1 | Release all tokens of `send_line` |
| send_line | input | IDX_W | Line index for the release |
| evt_valid | output | 1 | Event valid, one cycle after the handshake |
| evt_code | output | 3 | Event code |
| evt_line | output | IDX_W | Line the event belongs to |
| illegal_err | output | 1 | Pulse: illegal type or zero-token response |
| overflow_err | output | 1 | Sticky: token sum exceeded the total |
| send_valid | output | 1 | Token release message valid |
| send_count | output | TOK_W | Number of tokens released |

## Verification
The hardest case to reach is the exact-total boundary. A random count rarely brings stored plus incoming tokens to precisely MAX_TOKENS, because lines start full and most sums overflow. The stimulus therefore drains lines through the send command first and then feeds small token counts, so counters climb through the region just below the total. Directed steps also land on the total once for every response type. They also make a response and a release collide in the same cycle, which shows that send priority drops the response.

// File: rtl/tok_pkg.sv
package tok_pkg;

    localparam logic [2:0] RSP_ACK        = 3'd0;
    localparam logic [2:0] RSP_ACK_OWNER  = 3'd1;
    localparam logic [2:0] RSP_DATA_SHRD  = 3'd2;
    localparam logic [2:0] RSP_DATA_OWNER = 3'd3;

    typedef enum logic [2:0] {
        EV_NONE        = 3'd0,
        EV_DATA_ALL    = 3'd1,
        EV_OWNACK_ALL  = 3'd2,
        EV_ACK_ALL     = 3'd3,
        EV_DATA_OWNER  = 3'd4,
        EV_TOKENS      = 3'd5,
        EV_ACK_OWNER   = 3'd6,
        EV_REJECT      = 3'd7
    } tok_evt_e;

    typedef struct packed {
        tok_evt_e code;
        logic     illegal;
        logic     overflow;
        logic     accept;
    } tok_verdict_t;

    function automatic logic type_is_legal(input logic [2:0] t);
        return (t == RSP_ACK) || (t == RSP_ACK_OWNER) ||
               (t == RSP_DATA_SHRD) || (t == RSP_DATA_OWNER);
    endfunction

    function automatic tok_evt_e full_event(input logic [2:0] t);
        tok_evt_e e;
        case (t)
            RSP_DATA_OWNER, RSP_DATA_SHRD: e = EV_DATA_ALL;
            RSP_ACK_OWNER:                 e = EV_OWNACK_ALL;
            default:                       e = EV_ACK_ALL;
        endcase
        return e;
    endfunction

    function automatic tok_evt_e partial_event(input logic [2:0] t);
        tok_evt_e e;
        case (t)
            RSP_DATA_OWNER: e = EV_DATA_OWNER;
            RSP_ACK_OWNER:  e = EV_ACK_OWNER;
            default:        e = EV_TOKENS;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/tok_count_table.sv
module tok_count_table
    import tok_pkg::*;
#(
    parameter int MAX_TOKENS = 16,
    parameter int NUM_LINES  = 8,
    parameter int TOK_W      = $clog2(MAX_TOKENS + 1),
    parameter int IDX_W      = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [TOK_W-1:0] rd_a_val,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [TOK_W-1:0] rd_b_val,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TOK_W-1:0] wr_val
);

    localparam logic [TOK_W-1:0] FULL = TOK_W'(MAX_TOKENS);

    logic [TOK_W-1:0] cnt_q [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q[g] <= FULL;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                cnt_q[g] <= wr_val;
            end
        end
    end

    always_comb begin
        rd_a_val = cnt_q[rd_a_idx];
        rd_b_val = cnt_q[rd_b_idx];
    end

endmodule

// File: rtl/tok_event_decode.sv
module tok_event_decode
    import tok_pkg::*;
#(
    parameter int MAX_TOKENS = 16,
    parameter int TOK_W      = $clog2(MAX_TOKENS + 1)
) (
    input  logic [2:0]       rsp_type,
    input  logic [TOK_W-1:0] stored,
    input  logic [TOK_W-1:0] incoming,
    output tok_verdict_t     verdict,
    output logic [TOK_W-1:0] sum
);

    localparam logic [TOK_W:0] TOTAL = (TOK_W + 1)'(MAX_TOKENS);

    logic [TOK_W:0] sum_w;
    logic           bad_msg;

    always_comb begin
        sum_w   = {1'b0, stored} + {1'b0, incoming};
        sum     = sum_w[TOK_W-1:0];
        bad_msg = !type_is_legal(rsp_type) || (incoming == '0);

        verdict.illegal  = bad_msg;
        verdict.overflow = !bad_msg && (sum_w > TOTAL);
        verdict.accept   = !bad_msg && (sum_w <= TOTAL);

        if (!verdict.accept) begin
            verdict.code = EV_REJECT;
        end else if (sum_w == TOTAL) begin
            verdict.code = full_event(rsp_type);
        end else begin
            verdict.code = partial_event(rsp_type);
        end
    end

endmodule

// File: rtl/tok_resp_classifier.sv
module tok_resp_classifier
    import tok_pkg::*;
#(
    parameter int MAX_TOKENS = 16,
    parameter int NUM_LINES  = 8,
    localparam int TOK_W     = $clog2(MAX_TOKENS + 1),
    localparam int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rsp_valid,
    output logic             rsp_ready,
    input  logic [2:0]       rsp_type,
    input  logic [IDX_W-1:0] rsp_line,
    input  logic [TOK_W-1:0] rsp_tokens,
    input  logic             send_req,
    input  logic [IDX_W-1:0] send_line,
    output logic             evt_valid,
    output logic [2:0]       evt_code,
    output logic [IDX_W-1:0] evt_line,
    output logic             illegal_err,
    output logic             overflow_err,
    output logic             send_valid,
    output logic [TOK_W-1:0] send_count
);

    logic             take_rsp;
    logic [TOK_W-1:0] rsp_stored;
    logic [TOK_W-1:0] send_stored;
    logic [TOK_W-1:0] new_sum;
    tok_verdict_t     verdict;
    logic             send_fire;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [TOK_W-1:0] wr_val;

    assign rsp_ready = !send_req;
    assign take_rsp  = rsp_valid && rsp_ready;
    assign send_fire = send_req && (send_stored != '0);

    tok_count_table #(
        .MAX_TOKENS (MAX_TOKENS),
        .NUM_LINES  (NUM_LINES),
        .TOK_W      (TOK_W),
        .IDX_W      (IDX_W)
    ) u_table (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (rsp_line),
        .rd_a_val (rsp_stored),
        .rd_b_idx (send_line),
        .rd_b_val (send_stored),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_val   (wr_val)
    );

    tok_event_decode #(
        .MAX_TOKENS (MAX_TOKENS),
        .TOK_W      (TOK_W)
    ) u_decode (
        .rsp_type (rsp_type),
        .stored   (rsp_stored),
        .incoming (rsp_tokens),
        .verdict  (verdict),
        .sum      (new_sum)
    );

    always_comb begin
        wr_en  = 1'b0;
        wr_idx = rsp_line;
        wr_val = new_sum;
        if (send_fire) begin
            wr_en  = 1'b1;
            wr_idx = send_line;
            wr_val = '0;
        end else if (take_rsp && verdict.accept) begin
            wr_en  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_valid    <= 1'b0;
            evt_code     <= EV_NONE;
            evt_line     <= '0;
            illegal_err  <= 1'b0;
            overflow_err <= 1'b0;
            send_valid   <= 1'b0;
            send_count   <= '0;
        end else begin
            evt_valid    <= take_rsp;
            evt_code     <= take_rsp ? verdict.code : EV_NONE;
            if (take_rsp) begin
                evt_line <= rsp_line;
            end
            illegal_err  <= take_rsp && verdict.illegal;
            overflow_err <= overflow_err || (take_rsp && verdict.overflow);
            send_valid   <= send_fire;
            send_count   <= send_fire ? send_stored : '0;
        end
    end

endmodule

// File: rtl/tok_resp_checker.sv
module tok_resp_checker #(
    parameter int MAX_TOKENS = 16,
    parameter int TOK_W      = 5,
    parameter int IDX_W      = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic [TOK_W-1:0] rsp_tokens,
    input logic             send_req,
    input logic             evt_valid,
    input logic [2:0]       evt_code,
    input logic             illegal_err,
    input logic             overflow_err,
    input logic             send_valid,
    input logic [TOK_W-1:0] send_count
);

    a_r2_event_after_handshake: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ready) |=> evt_valid);

    a_r2_no_spurious_event: assert property (@(posedge clk) disable iff (rst)
        !(rsp_valid && rsp_ready) |=> (!evt_valid && evt_code == 3'd0));

    a_r3_code_nonzero_with_event: assert property (@(posedge clk) disable iff (rst)
        evt_valid |-> (evt_code != 3'd0));

    a_r5_illegal_is_reject: assert property (@(posedge clk) disable iff (rst)
        illegal_err |-> (evt_valid && evt_code == 3'd7));

    a_r5_zero_tokens_flagged: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ready && rsp_tokens == '0) |=> illegal_err);

    a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow_err |=> overflow_err);

    a_r8_send_count_range: assert property (@(posedge clk) disable iff (rst)
        send_valid |-> (send_count != '0 && send_count <= TOK_W'(MAX_TOKENS)));

    a_r8_silent_count_zero: assert property (@(posedge clk) disable iff (rst)
        !send_valid |-> (send_count == '0));

    a_r9_send_blocks_response: assert property (@(posedge clk) disable iff (rst)
        send_req |-> !rsp_ready);

endmodule

bind tok_resp_classifier tok_resp_checker #(
    .MAX_TOKENS (MAX_TOKENS),
    .TOK_W      (TOK_W),
    .IDX_W      (IDX_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_tokens   (rsp_tokens),
    .send_req     (send_req),
    .evt_valid    (evt_valid),
    .evt_code     (evt_code),
    .illegal_err  (illegal_err),
    .overflow_err (overflow_err),
    .send_valid   (send_valid),
    .send_count   (send_count)
);

// File: tb/sim_tok_resp_classifier.sv
`timescale 1ns/1ps
module sim_tok_resp_classifier;

    localparam int MAXT  = 16;
    localparam int LINES = 8;
    localparam int TW    = 5;
    localparam int IW    = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rsp_valid = 1'b0;
    logic          rsp_ready;
    logic [2:0]    rsp_type = '0;
    logic [IW-1:0] rsp_line = '0;
    logic [TW-1:0] rsp_tokens = '0;
    logic          send_req = 1'b0;
    logic [IW-1:0] send_line = '0;
    logic          evt_valid;
    logic [2:0]    evt_code;
    logic [IW-1:0] evt_line;
    logic          illegal_err;
    logic          overflow_err;
    logic          send_valid;
    logic [TW-1:0] send_count;

    int n_checks = 0;
    int n_errors = 0;
    int model_cnt [LINES];
    bit model_ovf = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tok_resp_classifier #(.MAX_TOKENS(MAXT), .NUM_LINES(LINES)) u0 (
        .clk(clk), .rst(rst), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_type(rsp_type), .rsp_line(rsp_line), .rsp_tokens(rsp_tokens),
        .send_req(send_req), .send_line(send_line), .evt_valid(evt_valid),
        .evt_code(evt_code), .evt_line(evt_line), .illegal_err(illegal_err),
        .overflow_err(overflow_err), .send_valid(send_valid), .send_count(send_count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_code(input int t, input int st, input int tk);
        int s;
        if (t > 3 || tk == 0) return 7;
        s = st + tk;
        if (s > MAXT) return 7;
        if (s == MAXT) begin
            if (t == 2 || t == 3) return 1;
            if (t == 1) return 2;
            return 3;
        end
        if (t == 3) return 4;
        if (t == 1) return 6;
        return 5;
    endfunction

    // called just after a falling edge
    task automatic do_rsp(input int t, input int ln, input int tk);
        int code, st;
        bit ill, ovf;
        st   = model_cnt[ln];
        code = exp_code(t, st, tk);
        ill  = (t > 3) || (tk == 0);
        ovf  = !ill && (st + tk > MAXT);
        rsp_type = 3'(t); rsp_line = IW'(ln); rsp_tokens = TW'(tk); rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
        check(evt_valid == 1'b1, "R2 evt_valid", int'(evt_valid), 1);
        check(evt_line == IW'(ln), "R2 evt_line", int'(evt_line), ln);
        if (code <= 3 && code >= 1)
            check(int'(evt_code) == code, "R3 all-tokens code", int'(evt_code), code);
        else if (code >= 4 && code <= 6)
            check(int'(evt_code) == code, "R4 partial code", int'(evt_code), code);
        else if (ill)
            check(int'(evt_code) == code, "R5 reject code", int'(evt_code), code);
        else
            check(int'(evt_code) == code, "R7 overflow code", int'(evt_code), code);
        check(illegal_err == ill, "R5 illegal_err", int'(illegal_err), int'(ill));
        if (ovf) model_ovf = 1;
        check(overflow_err == model_ovf, "R7 overflow_err", int'(overflow_err), int'(model_ovf));
        if (!ill && !ovf) model_cnt[ln] = st + tk;  // R6
    endtask

    task automatic do_send(input int ln, input bit with_rsp);
        int exp;
        exp = model_cnt[ln];
        send_req = 1'b1; send_line = IW'(ln);
        if (with_rsp) begin
            rsp_valid = 1'b1; rsp_type = 3'd0; rsp_line = IW'(ln); rsp_tokens = TW'(1);
        end
        #1;
        check(rsp_ready == 1'b0, "R9 rsp_ready low during send", int'(rsp_ready), 0);
        @(negedge clk);
        send_req = 1'b0; rsp_valid = 1'b0;
        if (with_rsp)
            check(evt_valid == 1'b0, "R9 collided response dropped", int'(evt_valid), 0);
        check(send_valid == (exp > 0), "R8 send_valid", int'(send_valid), int'(exp > 0));
        check(int'(send_count) == exp, "R8 send_count / R6 counter", int'(send_count), exp);
        model_cnt[ln] = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < LINES; i++) model_cnt[i] = MAXT;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(evt_valid == 1'b0, "R1 evt_valid", int'(evt_valid), 0);
        check(send_valid == 1'b0, "R1 send_valid", int'(send_valid), 0);
        check(overflow_err == 1'b0, "R1 overflow_err", int'(overflow_err), 0);
        check(illegal_err == 1'b0, "R1 illegal_err", int'(illegal_err), 0);
        check(rsp_ready == 1'b1, "R1 rsp_ready", int'(rsp_ready), 1);
        do_send(0, 0);            // R1 full count released
        do_send(0, 0);            // R8 empty line silent
        // R4 / R3 on line 0
        do_rsp(0, 0, 5);          // tokens
        do_rsp(3, 0, 11);         // data all
        do_send(0, 0);
        do_rsp(3, 0, 3);          // data owner
        do_rsp(1, 0, 2);          // ack owner
        do_rsp(2, 0, 1);          // shared partial -> tokens
        do_rsp(0, 0, 10);         // ack all
        do_send(0, 0);
        do_rsp(1, 0, 16);         // owner ack all
        do_send(0, 0);
        do_rsp(2, 0, 16);         // shared data all
        // R5 illegal type and zero tokens, counter kept
        do_rsp(5, 2, 3);
        do_send(2, 0);
        do_rsp(3, 2, 0);
        do_rsp(7, 2, 4);
        do_send(2, 0);            // expect silence
        // R9 collision
        do_rsp(0, 3, 0);
        do_send(3, 1);
        do_send(3, 0);            // response was dropped -> silent
        // idle cycle: no event
        @(negedge clk);
        check(evt_valid == 1'b0, "R2 idle no event", int'(evt_valid), 0);
        check(evt_code == 3'd0, "R2 idle code zero", int'(evt_code), 0);
        // random phase
        for (int i = 0; i < LINES; i++) do_send(i, 0);
        for (int it = 0; it < 600; it++) begin
            int ln, t, tk, pick;
            ln   = int'($urandom_range(0, LINES - 1));
            pick = int'($urandom_range(0, 9));
            if (pick < 2) begin
                do_send(ln, pick == 0);
            end else begin
                t  = (pick == 9) ? int'($urandom_range(4, 7)) : int'($urandom_range(0, 3));
                tk = int'($urandom_range(0, 6));
                if (pick == 8) tk = MAXT - model_cnt[ln];
                do_rsp(t, ln, tk);
            end
        end
        // R7 overflow directed
        do_send(1, 0);
        do_rsp(3, 1, 12);
        do_rsp(0, 1, 9);          // 21 > 16
        do_rsp(0, 4, 1);
        check(overflow_err == 1'b1, "R7 overflow sticky", int'(overflow_err), 1);
        do_send(1, 0);            // still 12
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule